// File: doc/BRIEF.md
# Cartridge Memory Bank Controller

This block watches processor writes that land in the lower half of a 16-bit address space (address bit 15 clear). It treats each such write as a control command and never as a data store. The command updates a small set of banking registers: a RAM enable flag, a ROM bank number, a RAM bank number, a banking-mode bit and a clock-register select. A two-bit type input chooses one of three controller flavours, and each flavour decodes the address range and the data fields in its own way.

The effective ROM and RAM bank numbers are outputs. The memory subsystem uses them to form the upper address bits of the switchable ROM window and the external RAM window. Both numbers are clipped to the configured bank counts, which are powers of two. One flavour also emits a single-cycle strobe, which an external clock block uses to capture its counters.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A write with address bits 15:13 = 000 sets ram_enable to 1 when data bits 3:0 equal 0xA, and to 0 for any other value. This holds for every active flavour.
- R2: In flavour A (ctrl_type=0), a write to 0x2000–0x3FFF loads data bits 4:0 into ROM bank bits 4:0. It keeps bits 6:5 and clears bits 8:7.
- R3: A value of zero is replaced by 1 before it is stored. This applies to data bits 4:0 in flavour A, to bits 6:0 in flavour B (ctrl_type=1) and to bits 7:0 in flavour C (ctrl_type=2).
- R4: In flavour A, a write to 0x4000–0x5FFF with banking_mode=0 loads data bits 1:0 into ROM bank bits 6:5. With banking_mode=1 it loads them into the RAM bank instead, and the ROM bank is left unchanged.
- R5: In flavour A, a write to 0x6000–0x7FFF loads banking_mode from data bit 0.
- R6: In flavour B, a write to 0x2000–0x3FFF sets a 7-bit ROM bank. A write to 0x4000–0x5FFF sets clk_sel to data bits 3:0 and the RAM bank to data bits 1:0.
- R7: In flavour B only, a write to 0x6000–0x7FFF makes latch_pulse high for exactly the one cycle after the write edge.
- R8: In flavour C, a write to 0x2000–0x2FFF sets ROM bank bits 7:0, and a write to 0x3000–0x3FFF sets ROM bank bit 8 from data bit 0. Each keeps the other part of the bank number.
- R9: In flavour C, a write to 0x4000–0x5FFF sets the RAM bank to data bits 3:0.
- R10: After every accepted write, the stored ROM bank is ANDed with ROM_BANKS−1 and the RAM bank with RAM_BANKS−1.
- R11: After reset, rom_bank=1, ram_bank=0, ram_enable=0, banking_mode=0, clk_sel=0 and latch_pulse=0.
- R12: Writes with address bit 15 set, and all writes while ctrl_type=3, leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctrl_type | input | 2 | Flavour select: 0=A, 1=B, 2=C, 3=inactive |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| rom_bank | output | 9 | Effective switchable ROM bank |
| ram_bank | output | 4 | Effective external RAM bank |
| ram_enable | output | 1 | External RAM access allowed |
| banking_mode | output | 1 | Flavour A mode bit (1 = upper bits steer RAM bank) |
| clk_sel | output | 4 | Flavour B clock-register select |
| latch_pulse | output | 1 | One-cycle capture strobe for an external clock block |

## Verification
Every banking register drives a port directly, so a wrong internal state appears on rom_bank, ram_bank, ram_enable, banking_mode or clk_sel in the cycle right after the write edge that produced it. A field-merge error only shows up on a later write that should have kept the corrupted bits. For that reason the directed sequences write one part of a bank number and then the other, and they check the kept half each time. A second instance with small bank counts exposes faults in the clipping that cannot be seen at the full widths.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

  localparam int ROM_W = 9;
  localparam int RAM_W = 4;
  localparam int SEL_W = 4;

  typedef enum logic [1:0] {
    FLAV_A   = 2'd0,
    FLAV_B   = 2'd1,
    FLAV_C   = 2'd2,
    FLAV_OFF = 2'd3
  } flavour_e;

  typedef enum logic [3:0] {
    CMD_NONE,
    CMD_RAM_EN,
    CMD_ROM5,
    CMD_UPPER2,
    CMD_MODE,
    CMD_ROM7,
    CMD_SEL,
    CMD_LATCH,
    CMD_ROM8,
    CMD_ROM_TOP,
    CMD_RAM4
  } bank_cmd_e;

  typedef struct packed {
    logic             ram_en;
    logic [ROM_W-1:0] rom;
    logic [RAM_W-1:0] ram;
    logic             mode;
    logic [SEL_W-1:0] sel;
  } bank_state_t;

endpackage

// File: rtl/cart_bank_rst_sync.sv
module cart_bank_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb shift_d = 1'b1;
    end else begin : g_chain
      always_comb shift_d = {shift_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign rst_n_sync = shift_q[STAGES-1];
endmodule

// File: rtl/cart_bank_decode.sv
module cart_bank_decode
  import cart_bank_pkg::*;
(
  input  logic [1:0] ctrl_type,
  input  logic       wr_en,
  input  logic [3:0] addr_hi,
  output bank_cmd_e  cmd
);
  always_comb begin
    cmd = CMD_NONE;
    if (wr_en && !addr_hi[3]) begin
      case (ctrl_type)
        FLAV_A: begin
          case (addr_hi[2:1])
            2'd0:    cmd = CMD_RAM_EN;
            2'd1:    cmd = CMD_ROM5;
            2'd2:    cmd = CMD_UPPER2;
            default: cmd = CMD_MODE;
          endcase
        end
        FLAV_B: begin
          case (addr_hi[2:1])
            2'd0:    cmd = CMD_RAM_EN;
            2'd1:    cmd = CMD_ROM7;
            2'd2:    cmd = CMD_SEL;
            default: cmd = CMD_LATCH;
          endcase
        end
        FLAV_C: begin
          case (addr_hi[2:0])
            3'd0, 3'd1: cmd = CMD_RAM_EN;
            3'd2:       cmd = CMD_ROM8;
            3'd3:       cmd = CMD_ROM_TOP;
            3'd4, 3'd5: cmd = CMD_RAM4;
            default:    cmd = CMD_NONE;
          endcase
        end
        default: cmd = CMD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/cart_bank_next.sv
module cart_bank_next
  import cart_bank_pkg::*;
#(
  parameter int ROM_BANKS = 512,
  parameter int RAM_BANKS = 16
) (
  input  bank_state_t cur,
  input  bank_cmd_e   cmd,
  input  logic [7:0]  data,
  output bank_state_t nxt
);
  localparam logic [ROM_W-1:0] ROM_MASK = ROM_W'(ROM_BANKS - 1);
  localparam logic [RAM_W-1:0] RAM_MASK = RAM_W'(RAM_BANKS - 1);

  logic [4:0] lo5;
  logic [6:0] lo7;
  logic [7:0] lo8;
  bank_state_t raw;

  always_comb begin
    lo5 = (data[4:0] == 5'd0) ? 5'd1 : data[4:0];
    lo7 = (data[6:0] == 7'd0) ? 7'd1 : data[6:0];
    lo8 = (data == 8'd0)      ? 8'd1 : data;
  end

  always_comb begin
    raw = cur;
    case (cmd)
      CMD_RAM_EN:  raw.ram_en = (data[3:0] == 4'hA);
      CMD_ROM5:    raw.rom    = {2'b00, cur.rom[6:5], lo5};
      CMD_UPPER2: begin
        if (cur.mode) raw.ram = {2'b00, data[1:0]};
        else          raw.rom = {2'b00, data[1:0], cur.rom[4:0]};
      end
      CMD_MODE:    raw.mode   = data[0];
      CMD_ROM7:    raw.rom    = {2'b00, lo7};
      CMD_SEL: begin
        raw.sel = data[3:0];
        raw.ram = {2'b00, data[1:0]};
      end
      CMD_ROM8:    raw.rom    = {cur.rom[8], lo8};
      CMD_ROM_TOP: raw.rom    = {data[0], cur.rom[7:0]};
      CMD_RAM4:    raw.ram    = data[3:0];
      default:     raw        = cur;
    endcase
  end

  always_comb begin
    nxt     = raw;
    nxt.rom = raw.rom & ROM_MASK;
    nxt.ram = raw.ram & RAM_MASK;
  end
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cart_bank_pkg::*;
#(
  parameter int ROM_BANKS   = 512,
  parameter int RAM_BANKS   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  ctrl_type,
  input  logic        wr_en,
  input  logic [15:0] wr_addr,
  input  logic [7:0]  wr_data,
  output logic [8:0]  rom_bank,
  output logic [3:0]  ram_bank,
  output logic        ram_enable,
  output logic        banking_mode,
  output logic [3:0]  clk_sel,
  output logic        latch_pulse
);
  localparam bank_state_t RESET_STATE = '{
    ram_en: 1'b0, rom: ROM_W'(1), ram: '0, mode: 1'b0, sel: '0};

  logic        rst_sync_n;
  bank_cmd_e   cmd;
  bank_state_t state_q;
  bank_state_t state_d;
  logic        state_ce;
  logic        latch_d;
  logic        latch_q;
  logic        unused_addr;

  assign unused_addr = ^wr_addr[11:0];

  cart_bank_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_sync_n)
  );

  cart_bank_decode u_decode (
    .ctrl_type (ctrl_type),
    .wr_en     (wr_en),
    .addr_hi   (wr_addr[15:12]),
    .cmd       (cmd)
  );

  cart_bank_next #(.ROM_BANKS(ROM_BANKS), .RAM_BANKS(RAM_BANKS)) u_next (
    .cur  (state_q),
    .cmd  (cmd),
    .data (wr_data),
    .nxt  (state_d)
  );

  always_comb begin
    state_ce = (cmd != CMD_NONE);
    latch_d  = (cmd == CMD_LATCH);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   state_q <= RESET_STATE;
    else if (state_ce) state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) latch_q <= 1'b0;
    else             latch_q <= latch_d;
  end

  assign rom_bank     = state_q.rom;
  assign ram_bank     = state_q.ram;
  assign ram_enable   = state_q.ram_en;
  assign banking_mode = state_q.mode;
  assign clk_sel      = state_q.sel;
  assign latch_pulse  = latch_q;
endmodule

// File: rtl/cart_bank_ctrl_chk.sv
module cart_bank_ctrl_chk #(
  parameter int ROM_BANKS = 512,
  parameter int RAM_BANKS = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  ctrl_type,
  input logic        wr_en,
  input logic [15:0] wr_addr,
  input logic [7:0]  wr_data,
  input logic [8:0]  rom_bank,
  input logic [3:0]  ram_bank,
  input logic        ram_enable,
  input logic        banking_mode,
  input logic        latch_pulse
);
  localparam logic [8:0] ROM_MASK = 9'(ROM_BANKS - 1);
  localparam logic [3:0] RAM_MASK = 4'(RAM_BANKS - 1);

  logic active_wr;
  assign active_wr = wr_en && !wr_addr[15] && (ctrl_type != 2'd3);

  assert_ram_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (active_wr && wr_addr[14:13] == 2'b00) |=> (ram_enable == ($past(wr_data[3:0]) == 4'hA)));

  assert_zero_remap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[15:12] == 4'h2 && ctrl_type == 2'd1 && wr_data[6:0] == 7'd0)
      |=> rom_bank[0]);

  assert_mode_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[15:13] == 3'b011 && ctrl_type == 2'd0)
      |=> (banking_mode == $past(wr_data[0])));

  assert_latch_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    latch_pulse |-> $past(wr_en && wr_addr[15:13] == 3'b011 && ctrl_type == 2'd1));

  assert_bank_clip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((rom_bank & ~ROM_MASK) == 9'd0) && ((ram_bank & ~RAM_MASK) == 4'd0));

  assert_ignored_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr[15] || ctrl_type == 2'd3))
      |=> ($stable(rom_bank) && $stable(ram_bank) && $stable(ram_enable) && $stable(banking_mode)));
endmodule

bind cart_bank_ctrl cart_bank_ctrl_chk #(.ROM_BANKS(ROM_BANKS), .RAM_BANKS(RAM_BANKS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .ctrl_type    (ctrl_type),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .rom_bank     (rom_bank),
  .ram_bank     (ram_bank),
  .ram_enable   (ram_enable),
  .banking_mode (banking_mode),
  .latch_pulse  (latch_pulse)
);

// File: tb/cart_bank_ctrl_tb.sv
module cart_bank_ctrl_tb;
  logic        clk;
  logic        rst_n;
  logic [1:0]  ctrl_type;
  logic        wr_en;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  logic [8:0]  rom_bank, rom_s;
  logic [3:0]  ram_bank, ram_s;
  logic        ram_enable, en_s;
  logic        banking_mode, mode_s;
  logic [3:0]  clk_sel, sel_s;
  logic        latch_pulse, latch_s;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  cart_bank_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_type(ctrl_type), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rom_bank(rom_bank),
    .ram_bank(ram_bank), .ram_enable(ram_enable), .banking_mode(banking_mode),
    .clk_sel(clk_sel), .latch_pulse(latch_pulse));

  cart_bank_ctrl #(.ROM_BANKS(32), .RAM_BANKS(4)) u_dut_small (
    .clk(clk), .rst_n(rst_n), .ctrl_type(ctrl_type), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rom_bank(rom_s),
    .ram_bank(ram_s), .ram_enable(en_s), .banking_mode(mode_s),
    .clk_sel(sel_s), .latch_pulse(latch_s));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] ty, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ctrl_type = ty; wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11 rom", 16'(rom_bank), 16'h1);
    chk("R11 ram", 16'(ram_bank), 16'h0);
    chk("R11 en", 16'(ram_enable), 16'h0);
    chk("R11 mode", 16'(banking_mode), 16'h0);
    chk("R11 sel", 16'(clk_sel), 16'h0);
    chk("R11 latch", 16'(latch_pulse), 16'h0);
  endtask

  task automatic t_enable;
    wr(2'd0, 16'h0000, 8'h0A); chk("R1 en A", 16'(ram_enable), 16'h1);
    wr(2'd0, 16'h1FFF, 8'h1A); chk("R1 nibble", 16'(ram_enable), 16'h1);
    wr(2'd0, 16'h0000, 8'h0B); chk("R1 off", 16'(ram_enable), 16'h0);
    wr(2'd2, 16'h1000, 8'hFA); chk("R1 en C", 16'(ram_enable), 16'h1);
  endtask

  task automatic t_flavour_a;
    wr(2'd0, 16'h2000, 8'h15); chk("R2 lo5", 16'(rom_bank), 16'h015);
    wr(2'd0, 16'h2000, 8'h00); chk("R3 A zero", 16'(rom_bank), 16'h001);
    wr(2'd0, 16'h3FFF, 8'hE0); chk("R3 A hi bits", 16'(rom_bank), 16'h001);
    wr(2'd0, 16'h4000, 8'h03); chk("R4 mode0 rom", 16'(rom_bank), 16'h061);
    chk("R10 small rom", 16'(rom_s), 16'h001);
    wr(2'd0, 16'h2000, 8'h04); chk("R2 keep 6:5", 16'(rom_bank), 16'h064);
    wr(2'd0, 16'h6000, 8'h01); chk("R5 mode1", 16'(banking_mode), 16'h1);
    wr(2'd0, 16'h5FFF, 8'h02); chk("R4 mode1 ram", 16'(ram_bank), 16'h2);
    chk("R4 mode1 rom kept", 16'(rom_bank), 16'h064);
    chk("R10 small rom4", 16'(rom_s), 16'h004);
    wr(2'd0, 16'h7FFF, 8'hFE); chk("R5 mode0", 16'(banking_mode), 16'h0);
    chk("R7 no strobe A", 16'(latch_pulse), 16'h0);
  endtask

  task automatic t_flavour_b;
    wr(2'd1, 16'h2000, 8'h00); chk("R3 B zero", 16'(rom_bank), 16'h001);
    wr(2'd1, 16'h3000, 8'hFF); chk("R6 rom7", 16'(rom_bank), 16'h07F);
    wr(2'd1, 16'h2000, 8'h80); chk("R3 B bit7", 16'(rom_bank), 16'h001);
    wr(2'd1, 16'h4000, 8'h0B);
    chk("R6 sel", 16'(clk_sel), 16'hB);
    chk("R6 ram", 16'(ram_bank), 16'h3);
    wr(2'd1, 16'h6000, 8'h01); chk("R7 strobe", 16'(latch_pulse), 16'h1);
    @(negedge clk); chk("R7 one cycle", 16'(latch_pulse), 16'h0);
  endtask

  task automatic t_flavour_c;
    wr(2'd2, 16'h2000, 8'h00); chk("R3 C zero", 16'(rom_bank), 16'h001);
    wr(2'd2, 16'h2000, 8'h5A); chk("R8 lo8", 16'(rom_bank), 16'h05A);
    wr(2'd2, 16'h3000, 8'h01); chk("R8 bit8", 16'(rom_bank), 16'h15A);
    chk("R10 small rom9", 16'(rom_s), 16'h01A);
    wr(2'd2, 16'h2FFF, 8'h00); chk("R8 keep bit8", 16'(rom_bank), 16'h101);
    wr(2'd2, 16'h3FFF, 8'hFE); chk("R8 clr bit8", 16'(rom_bank), 16'h001);
    wr(2'd2, 16'h4000, 8'h0F); chk("R9 ram15", 16'(ram_bank), 16'hF);
    chk("R10 small ram", 16'(ram_s), 16'h3);
    wr(2'd2, 16'h5FFF, 8'h27); chk("R9 ram7", 16'(ram_bank), 16'h7);
  endtask

  task automatic t_ignore;
    wr(2'd2, 16'h0000, 8'h00);
    wr(2'd3, 16'h0000, 8'h0A); chk("R12 off en", 16'(ram_enable), 16'h0);
    wr(2'd3, 16'h2000, 8'h33); chk("R12 off rom", 16'(rom_bank), 16'h001);
    wr(2'd2, 16'h8000, 8'h0A); chk("R12 hi en", 16'(ram_enable), 16'h0);
    wr(2'd2, 16'hA000, 8'h44); chk("R12 hi rom", 16'(rom_bank), 16'h001);
    chk("R12 hi ram", 16'(ram_bank), 16'h7);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R11 watchdog act=hung exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ctrl_type = 2'd0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_enable;
    t_flavour_a;
    t_flavour_b;
    t_flavour_c;
    t_ignore;
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule